// File: doc/BRIEF.md
# Burst-mode handshake controller

This block is a four-state machine that reacts to complete groups of input edges, called bursts, and not to single input levels. It watches three handshake inputs (`in_a`, `in_b`, `in_c`) and drives two handshake outputs (`out_x`, `out_y`). In each state a small set of bursts is enabled. The machine records which burst inputs have toggled since the current burst began. When every input of an enabled burst has toggled, the machine changes its outputs and its state in a single step.

The block is a clocked model of a controller that is normally asynchronous. The inputs pass through a parameterised register chain. After every output change the environment must keep its inputs steady for a hold window. This is the fundamental-mode assumption: a new burst may not start until the previous response has settled.

Any departure from the protocol sets a sticky error flag and freezes the machine until reset. The departures are: an input outside every enabled burst, a burst input that flips back before its burst completes, two competing bursts completing together, and an input change inside the hold window.

Top module: `burst_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `out_x`, `out_y` and `err_o` are 0 and the machine is idle, with a baseline of a=b=c=0.
- R2: From idle, the outputs stay unchanged until both a and b have risen. The two may rise in either order or together. `out_y` rises when the second one arrives.
- R3: While `out_y` is high with a=b=1, a rise on c lowers `out_y`. A later fall on c raises `out_y` again.
- R4: While `out_y` is high with a=b=1 and c=0, a fall on a sets `out_x` to 1 and `out_y` to 0 in the same cycle.
- R5: While `out_x` is high, a fall on b clears `out_x` and returns the machine to idle, so a new a/b burst is accepted.
- R6: An input change that completes a burst shows on the outputs after the second rising clock edge that follows it, with the default of one sampling stage.
- R7: Any input change driven in the first HOLD_CYC clock cycles after an output change sets `err_o`. The default HOLD_CYC is 2. A change in cycle HOLD_CYC+1 is accepted.
- R8: An input that belongs to no burst enabled in the current state sets `err_o`. An example is c changing while idle.
- R9: An input of the current burst that flips back to its starting value before the burst completes sets `err_o`.
- R10: While `out_y` is high with a=b=1 and c=0, a change on a and a change on c in the same sample set `err_o`.
- R11: Once set, `err_o` stays 1 and `out_x`/`out_y` keep their values whatever the inputs do, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Handshake input a |
| in_b | input | 1 | Handshake input b |
| in_c | input | 1 | Handshake input c |
| out_x | output | 1 | Handshake output x (registered) |
| out_y | output | 1 | Handshake output y (registered) |
| err_o | output | 1 | Sticky protocol-violation flag (registered) |

## Verification
The hardest case to reach is the edge of the hold window. An input change must land exactly one cycle inside the window, and in a separate run exactly one cycle outside it. Each case is counted from the clock edge on which the outputs changed. The stimulus drives inputs on falling edges and counts falling edges from the first one after the output change. This places the offending change in cycle 2 for one run and in cycle 3 for another. A second hard case is the competing bursts of R10. Here a and c must change within a single sample, so both are driven on the same falling edge.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int NIN = 3;
  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_C = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_LOW  = 2'd2,
    ST_XON  = 2'd3
  } bst_t;

  // Inputs that take part in a burst enabled in each state
  function automatic logic [NIN-1:0] allow_mask(input bst_t s);
    case (s)
      ST_IDLE: allow_mask = 3'b011;
      ST_UP:   allow_mask = 3'b101;
      ST_LOW:  allow_mask = 3'b100;
      default: allow_mask = 3'b010;
    endcase
  endfunction
endpackage

// File: rtl/burst_sampler.sv
module burst_sampler #(
  parameter int W      = 3,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/burst_tracker.sv
module burst_tracker #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic         fire,
  output logic [W-1:0] chg,
  output logic [W-1:0] revert
);
  logic [W-1:0] base_q;
  logic [W-1:0] seen_q;

  // Toggled relative to the value held when the current burst began
  assign chg    = smp ^ base_q;
  // Seen to toggle earlier, but back at the starting value now
  assign revert = seen_q & ~chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      seen_q <= '0;
    end else if (fire) begin
      base_q <= smp;
      seen_q <= '0;
    end else begin
      seen_q <= seen_q | chg;
    end
  end
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
  import burst_pkg::*;
#(
  parameter int HOLD_LOAD = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] chg,
  input  logic [NIN-1:0] revert,
  output logic           fire,
  output logic           out_x,
  output logic           out_y,
  output logic           err_o
);
  localparam int CW = $clog2(HOLD_LOAD + 1);

  bst_t          st_q, st_n;
  logic          x_n, y_n, err_c;
  logic [CW-1:0] hold_q;

  always_comb begin
    st_n  = st_q;
    x_n   = out_x;
    y_n   = out_y;
    fire  = 1'b0;
    err_c = 1'b0;
    if (!err_o) begin
      if (hold_q != '0) begin
        if (|chg) err_c = 1'b1;
      end else if ((|(chg & ~allow_mask(st_q))) || (|revert)) begin
        err_c = 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: if (chg[BIT_A] && chg[BIT_B]) begin
            fire = 1'b1; st_n = ST_UP; y_n = 1'b1;
          end
          ST_UP: begin
            if (chg[BIT_A] && chg[BIT_C]) begin
              err_c = 1'b1;
            end else if (chg[BIT_C]) begin
              fire = 1'b1; st_n = ST_LOW; y_n = 1'b0;
            end else if (chg[BIT_A]) begin
              fire = 1'b1; st_n = ST_XON; x_n = 1'b1; y_n = 1'b0;
            end
          end
          ST_LOW: if (chg[BIT_C]) begin
            fire = 1'b1; st_n = ST_UP; y_n = 1'b1;
          end
          default: if (chg[BIT_B]) begin
            fire = 1'b1; st_n = ST_IDLE; x_n = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      out_x  <= 1'b0;
      out_y  <= 1'b0;
      err_o  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (err_c) err_o <= 1'b1;
      if (fire) begin
        st_q   <= st_n;
        out_x  <= x_n;
        out_y  <= y_n;
        hold_q <= CW'(HOLD_LOAD);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int SYNC_STAGES = 1,
  parameter int HOLD_CYC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_x,
  output logic out_y,
  output logic err_o
);
  // Changes driven in cycle j after a response reach the sequencer at edge j+SYNC_STAGES
  localparam int HOLD_LOAD = HOLD_CYC + SYNC_STAGES;

  logic [NIN-1:0] raw, smp, chg, revert;
  logic           fire;

  assign raw = {in_c, in_b, in_a};

  burst_sampler #(.W(NIN), .STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .din(raw), .dout(smp)
  );

  burst_tracker #(.W(NIN)) u_trk (
    .clk(clk), .rst(rst), .smp(smp), .fire(fire), .chg(chg), .revert(revert)
  );

  burst_sequencer #(.HOLD_LOAD(HOLD_LOAD)) u_seq (
    .clk(clk), .rst(rst), .chg(chg), .revert(revert), .fire(fire),
    .out_x(out_x), .out_y(out_y), .err_o(err_o)
  );
endmodule

// File: rtl/burst_ctrl_chk.sv
module burst_ctrl_chk #(
  parameter int SYNC_STAGES = 1,
  parameter int HOLD_CYC    = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       out_x,
  input logic       out_y,
  input logic       err_o,
  input logic [2:0] smp
);
  localparam int L  = HOLD_CYC + SYNC_STAGES;
  localparam int GW = $clog2(L + 3);

  logic          rst_q = 1'b0;
  logic [1:0]    prev_xy;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      prev_xy <= 2'b00;
      gap     <= GW'(L + 1);
    end else begin
      prev_xy <= {out_x, out_y};
      if ({out_x, out_y} != prev_xy) gap <= GW'(1);
      else if (gap < GW'(L + 1))    gap <= gap + GW'(1);
    end
  end

  // R1: one edge after reset the outputs are cleared
  always_ff @(posedge clk) begin
    if (rst_q) a_r1_reset_state : assert (!out_x && !out_y && !err_o);
  end

  a_r11_err_sticky : assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  a_r11_outputs_frozen : assert property (@(posedge clk) disable iff (rst)
    err_o |=> $stable({out_x, out_y}));

  a_r4_x_rises_with_y_fall : assert property (@(posedge clk) disable iff (rst)
    $rose(out_x) |-> (!out_y && $past(out_y)));

  a_r5_x_falls_alone : assert property (@(posedge clk) disable iff (rst)
    $fell(out_x) |-> !out_y);

  a_r2_y_rise_needs_ab : assert property (@(posedge clk) disable iff (rst)
    $rose(out_y) |-> $past(smp[0] && smp[1]));

  a_r7_min_gap : assert property (@(posedge clk) disable iff (rst)
    ({out_x, out_y} != prev_xy) |-> (gap >= GW'(L + 1)));
endmodule

bind burst_ctrl burst_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .out_x(out_x), .out_y(out_y), .err_o(err_o), .smp(smp)
);

// File: tb/burst_ctrl_bench.sv
module burst_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
  logic out_x, out_y, err_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_ctrl u_burst_ctrl (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_x(out_x), .out_y(out_y), .err_o(err_o)
  );

  // {c,b,a}, expected {x,y}, expected err, requirement number
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {3'b001, 2'b00, 1'b0, 4'd2},  // R2 a alone: no response
    {3'b011, 2'b01, 1'b0, 4'd2},  // R2 b completes: y rises
    {3'b111, 2'b00, 1'b0, 4'd3},  // R3 c+ lowers y
    {3'b011, 2'b01, 1'b0, 4'd3},  // R3 c- raises y
    {3'b111, 2'b00, 1'b0, 4'd3},  // R3 again
    {3'b011, 2'b01, 1'b0, 4'd3},  // R3 again
    {3'b010, 2'b10, 1'b0, 4'd4},  // R4 a- : x up, y down
    {3'b000, 2'b00, 1'b0, 4'd5},  // R5 b- : back to idle
    {3'b010, 2'b00, 1'b0, 4'd2},  // R2 b first: no response
    {3'b011, 2'b01, 1'b0, 4'd2},  // R2 a completes
    {3'b010, 2'b10, 1'b0, 4'd4},  // R4
    {3'b000, 2'b00, 1'b0, 4'd5}   // R5
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {x,y,err} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] cba);
    {in_c, in_b, in_a} = cba;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(3'b000);
    cyc(2);
    rst = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    check("R1", {out_x, out_y, err_o}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:7]);
      cyc(4);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {out_x, out_y, err_o},
            {VEC[i][6:5], VEC[i][4]});
    end

    // R6 latency: response after the second rising edge
    do_reset();
    check("R1 after reset", {out_x, out_y, err_o}, 3'b000);
    drive(3'b011);
    cyc(1);
    check("R6 one edge", {out_x, out_y, err_o}, 3'b000);
    cyc(1);
    check("R6 two edges", {out_x, out_y, err_o}, 3'b010);
    // R7 change in cycle 1 after response
    drive(3'b111);
    cyc(4);
    check("R7 early change", {out_x, out_y, err_o}, 3'b011);
    // R11 sticky and frozen
    drive(3'b011);
    cyc(4);
    check("R11 frozen", {out_x, out_y, err_o}, 3'b011);

    // R7 boundary: cycle HOLD_CYC after response is still inside window
    do_reset();
    drive(3'b011);
    cyc(2);
    cyc(1);
    drive(3'b111);
    cyc(4);
    check("R7 last hold cycle", {out_x, out_y, err_o}, 3'b011);

    // R7 boundary: cycle HOLD_CYC+1 is accepted
    do_reset();
    drive(3'b011);
    cyc(2);
    cyc(2);
    drive(3'b111);
    cyc(4);
    check("R7 after window", {out_x, out_y, err_o}, 3'b000);

    // R8 stray input while idle
    do_reset();
    drive(3'b100);
    cyc(4);
    check("R8 stray c", {out_x, out_y, err_o}, 3'b001);
    drive(3'b111);
    cyc(4);
    check("R11 no response after error", {out_x, out_y, err_o}, 3'b001);

    // R9 burst input reverts
    do_reset();
    drive(3'b001);
    cyc(4);
    check("R9 partial", {out_x, out_y, err_o}, 3'b000);
    drive(3'b000);
    cyc(4);
    check("R9 revert", {out_x, out_y, err_o}, 3'b001);

    // R10 competing bursts in one sample
    do_reset();
    drive(3'b011);
    cyc(4);
    check("R10 setup", {out_x, out_y, err_o}, 3'b010);
    drive(3'b110);
    cyc(4);
    check("R10 conflict", {out_x, out_y, err_o}, 3'b011);

    // R1 reset clears error
    do_reset();
    check("R1 clears error", {out_x, out_y, err_o}, 3'b000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule